// File: doc/BRIEF.md
# Oscillator Tuning Word Conditioner

This block sits between a digital frequency-synthesis loop and the switched-capacitor banks of a digitally controlled oscillator. The loop delivers signed tuning words for four banks. The first is a coarse bank for process, voltage and temperature. The second is a coarse acquisition bank. The last two are tracking banks, one integer and one fractional. The block turns these words into the unsigned control vectors that switch the capacitor elements.

A two-bit mode input selects which bank accepts new words. Words are taken only on a reference-rate strobe. The coarse banks are loaded one after the other while the loop locks, and they keep their last code once their phase is over. In tracking mode the integer and fractional words keep updating. The fractional word feeds a second-order MASH modulator that runs on every fast clock. The small carry sequence it produces is added to the integer code, saturated, and sent to the tracking bank as a unit-weighted vector. The acquisition code is also sent out unit-weighted, and the coarse PVT code is sent out as offset binary.

Top module: `dco_otw_cond`

## Requirements
- R1: While rst_n is low, pvt_code is 2^(PVT_W-1), acq_therm has its lowest 2^(ACQ_W-1) bits set, trk_therm has its lowest 2^(TI_W-1) bits set, and the dither state is zero.
- R2: Each signed word is converted to an unsigned code by adding 2^(W-1), where W is the width of that word. The most negative word maps to 0 and the most positive word maps to all ones.
- R3: The PVT code loads pvt_word on a rising clock edge only when mode is 2'b00 and ref_tick is 1. At every other edge it keeps its value.
- R4: The acquisition code loads acq_word on a rising clock edge only when mode is 2'b01 and ref_tick is 1. At every other edge it keeps its value.
- R5: The integer and fractional tracking words are loaded together only when mode is 2'b10 and ref_tick is 1.
- R6: Mode 2'b11 (hold) loads no bank. After one clock edge in hold, the dither is zero and trk_therm shows the plain integer tracking code.
- R7: In acq_therm and trk_therm, bit i is 1 exactly when the code is greater than i. A code of n therefore sets bits 0 to n-1.
- R8: At each clock edge in mode 2'b10, the dither becomes c1 + c2 - c2', in the range -1 to +2. Here c1 is the carry of the first accumulator (acc1 + frac), and c2 is the carry of the second accumulator (acc2 + new acc1). c2' is the c2 from the previous tracking edge. In any other mode the dither becomes 0 and both accumulators keep their values.
- R9: The tracking code is the integer tracking code plus the dither, saturated to the range 0 to 2^TI_W-1.
- R10: With a constant fractional word f held for 2^FRAC_W tracking clocks from cleared accumulators, the dither sums to f or f+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock. The dither updates on every edge. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| mode | input | 2 | 00 PVT, 01 acquisition, 10 tracking, 11 hold. |
| ref_tick | input | 1 | Reference-rate strobe that allows words to load. |
| pvt_word | input | PVT_W | Signed PVT bank word. |
| acq_word | input | ACQ_W | Signed acquisition bank word. |
| trk_int_word | input | TI_W | Signed integer tracking word. |
| trk_frac_word | input | FRAC_W | Unsigned fractional tracking word. |
| pvt_code | output | PVT_W | Offset-binary PVT bank code. |
| acq_therm | output | 2^ACQ_W-1 | Unit-weighted acquisition vector. |
| trk_therm | output | 2^TI_W-1 | Unit-weighted, dithered integer tracking vector. |

## Verification
The bench builds the block with PVT_W=6, ACQ_W=3, TI_W=3 and FRAC_W=8. With a 3-bit integer tracking word, the dithered sum reaches both saturation rails often: a word at +3 gets dithered upward and a word at -4 gets dithered downward. The 8-bit fractional word keeps a full 256-clock dither period short, so the long-run average can be checked exactly. The small widths also let random words hit the extreme signed values for every bank many times.

// File: rtl/dco_otw_pkg.sv
package dco_otw_pkg;
  typedef enum logic [1:0] {
    MODE_PVT  = 2'b00,
    MODE_ACQ  = 2'b01,
    MODE_TRK  = 2'b10,
    MODE_HOLD = 2'b11
  } bank_mode_e;

  localparam int DITH_W = 3;
endpackage

// File: rtl/otw_bank_reg.sv
module otw_bank_reg #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] word,
  output logic        [W-1:0] code
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_d;

  // offset binary: flipping the sign bit adds 2^(W-1)
  always_comb begin
    code_d = code;
    if (load) code_d = {~word[W-1], word[W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= MID;
    else        code <= code_d;
  end
endmodule

// File: rtl/otw_therm_enc.sv
module otw_therm_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0]        code,
  output logic [(1<<W)-2:0]   therm
);
  localparam int N = (1 << W) - 1;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign therm[i] = (code > W'(i));
  end
endmodule

// File: rtl/otw_mash2.sv
module otw_mash2 #(
  parameter int FW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [FW-1:0]       frac,
  output logic signed [2:0]   dith
);
  logic [FW-1:0]      acc1, acc2, acc1_d, acc2_d;
  logic               c2_q, c2_d;
  logic signed [2:0]  dith_d;
  logic [FW:0]        sum1, sum2;

  always_comb begin
    sum1   = {1'b0, acc1} + {1'b0, frac};
    sum2   = {1'b0, acc2} + {1'b0, sum1[FW-1:0]};
    acc1_d = acc1;
    acc2_d = acc2;
    c2_d   = c2_q;
    dith_d = 3'sd0;
    if (en) begin
      acc1_d = sum1[FW-1:0];
      acc2_d = sum2[FW-1:0];
      c2_d   = sum2[FW];
      dith_d = $signed({2'b00, sum1[FW]}) + $signed({2'b00, sum2[FW]})
             - $signed({2'b00, c2_q});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc1 <= '0;
      acc2 <= '0;
      c2_q <= 1'b0;
      dith <= 3'sd0;
    end else begin
      acc1 <= acc1_d;
      acc2 <= acc2_d;
      c2_q <= c2_d;
      dith <= dith_d;
    end
  end
endmodule

// File: rtl/dco_otw_cond.sv
module dco_otw_cond #(
  parameter int PVT_W  = 8,
  parameter int ACQ_W  = 5,
  parameter int TI_W   = 4,
  parameter int FRAC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode,
  input  logic                       ref_tick,
  input  logic signed [PVT_W-1:0]    pvt_word,
  input  logic signed [ACQ_W-1:0]    acq_word,
  input  logic signed [TI_W-1:0]     trk_int_word,
  input  logic [FRAC_W-1:0]          trk_frac_word,
  output logic [PVT_W-1:0]           pvt_code,
  output logic [(1<<ACQ_W)-2:0]      acq_therm,
  output logic [(1<<TI_W)-2:0]       trk_therm
);
  import dco_otw_pkg::*;

  localparam int TI_N  = (1 << TI_W) - 1;
  localparam int SUM_W = TI_W + 3;

  logic              ld_pvt, ld_acq, ld_trk, mash_en;
  logic [ACQ_W-1:0]  acq_code;
  logic [TI_W-1:0]   ti_code, trk_code;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic signed [2:0] dith;
  logic signed [SUM_W-1:0] ti_sum;

  always_comb begin
    ld_pvt  = ref_tick && (mode == MODE_PVT);
    ld_acq  = ref_tick && (mode == MODE_ACQ);
    ld_trk  = ref_tick && (mode == MODE_TRK);
    mash_en = (mode == MODE_TRK);
  end

  otw_bank_reg #(.W(PVT_W)) i_pvt_reg (
    .clk(clk), .rst_n(rst_n), .load(ld_pvt), .word(pvt_word), .code(pvt_code));

  otw_bank_reg #(.W(ACQ_W)) i_acq_reg (
    .clk(clk), .rst_n(rst_n), .load(ld_acq), .word(acq_word), .code(acq_code));

  otw_bank_reg #(.W(TI_W)) i_ti_reg (
    .clk(clk), .rst_n(rst_n), .load(ld_trk), .word(trk_int_word), .code(ti_code));

  always_comb begin
    frac_d = frac_q;
    if (ld_trk) frac_d = trk_frac_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  otw_mash2 #(.FW(FRAC_W)) i_mash (
    .clk(clk), .rst_n(rst_n), .en(mash_en), .frac(frac_q), .dith(dith));

  // integer code plus dither, clamped to the unit-weighted range
  always_comb begin
    ti_sum = $signed({3'b000, ti_code}) + $signed({{TI_W{dith[2]}}, dith});
    if (ti_sum < 0)
      trk_code = '0;
    else if (ti_sum > $signed(SUM_W'(TI_N)))
      trk_code = TI_W'(TI_N);
    else
      trk_code = ti_sum[TI_W-1:0];
  end

  otw_therm_enc #(.W(ACQ_W)) i_acq_enc (.code(acq_code), .therm(acq_therm));
  otw_therm_enc #(.W(TI_W))  i_trk_enc (.code(trk_code), .therm(trk_therm));
endmodule

// File: rtl/dco_otw_cond_chk.sv
module dco_otw_cond_chk #(
  parameter int PVT_W  = 8,
  parameter int ACQ_W  = 5,
  parameter int TI_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            mode,
  input logic                  ref_tick,
  input logic [PVT_W-1:0]      pvt_code,
  input logic [(1<<ACQ_W)-2:0] acq_therm,
  input logic [(1<<TI_W)-2:0]  trk_therm,
  input logic signed [2:0]     dith
);
  localparam int ACQ_N = (1 << ACQ_W) - 1;
  localparam int TI_N  = (1 << TI_W) - 1;
  localparam logic [ACQ_N-1:0] ACQ_ONES = '1;
  localparam logic [TI_N-1:0]  TI_ONES  = '1;

  assert_pvt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 || !ref_tick) |=> $stable(pvt_code));

  assert_acq_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01 || !ref_tick) |=> $stable(acq_therm));

  assert_acq_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acq_therm == (ACQ_ONES >> (ACQ_N - $countones(acq_therm))));

  assert_trk_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trk_therm == (TI_ONES >> (TI_N - $countones(trk_therm))));

  assert_dith_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |=> (dith == 3'sd0));

  assert_dith_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dith[2] |-> (dith == -3'sd1));

  assert_hold_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) == 2'b11) |=> $stable(trk_therm));
endmodule

bind dco_otw_cond dco_otw_cond_chk #(
  .PVT_W(PVT_W), .ACQ_W(ACQ_W), .TI_W(TI_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ref_tick(ref_tick),
  .pvt_code(pvt_code), .acq_therm(acq_therm), .trk_therm(trk_therm),
  .dith(dith)
);

// File: tb/test_dco_otw_cond.sv
`timescale 1ns/1ps
module test_dco_otw_cond;
  localparam int P = 6, A = 3, T = 3, F = 8;
  localparam int AN = (1 << A) - 1, TN = (1 << T) - 1, FMASK = (1 << F) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic ref_tick;
  logic signed [P-1:0] pvt_word;
  logic signed [A-1:0] acq_word;
  logic signed [T-1:0] trk_int_word;
  logic [F-1:0] trk_frac_word;
  logic [P-1:0] pvt_code;
  logic [AN-1:0] acq_therm;
  logic [TN-1:0] trk_therm;

  int n_chk = 0, n_bad = 0;
  int m_pvt, m_acq, m_ti, m_frac, m_a1, m_a2, m_c2p, m_dith;
  int seed = 32'h5eed;

  always #10 clk = ~clk;

  dco_otw_cond #(.PVT_W(P), .ACQ_W(A), .TI_W(T), .FRAC_W(F)) i_dco_otw_cond (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref_tick(ref_tick),
    .pvt_word(pvt_word), .acq_word(acq_word), .trk_int_word(trk_int_word),
    .trk_frac_word(trk_frac_word), .pvt_code(pvt_code),
    .acq_therm(acq_therm), .trk_therm(trk_therm));

  function automatic int sat(int v);
    if (v < 0) return 0;
    if (v > TN) return TN;
    return v;
  endfunction

  function automatic logic [63:0] unit(int n);
    logic [63:0] u = '0;
    for (int i = 0; i < n; i++) u[i] = 1'b1;
    return u;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 R3 pvt"}, 64'(pvt_code), 64'(m_pvt));
    chk({tag, " R4 R7 acq"}, 64'(acq_therm), unit(m_acq));
    chk({tag, " R8 R9 trk"}, 64'(trk_therm), unit(sat(m_ti + m_dith)));
  endtask

  task automatic model_reset();
    m_pvt = 1 << (P-1); m_acq = 1 << (A-1); m_ti = 1 << (T-1);
    m_frac = 0; m_a1 = 0; m_a2 = 0; m_c2p = 0; m_dith = 0;
  endtask

  // one clock: inputs already driven; update model at the edge, compare at negedge
  task automatic step(string tag);
    int s1, s2, c1, c2;
    @(posedge clk);
    if (mode == 2'b10) begin
      s1 = m_a1 + m_frac; c1 = s1 >> F; m_a1 = s1 & FMASK;
      s2 = m_a2 + m_a1;   c2 = s2 >> F; m_a2 = s2 & FMASK;
      m_dith = c1 + c2 - m_c2p; m_c2p = c2;
    end else m_dith = 0;
    if (ref_tick) begin
      if (mode == 2'b00) m_pvt = int'(pvt_word) + (1 << (P-1));
      if (mode == 2'b01) m_acq = int'(acq_word) + (1 << (A-1));
      if (mode == 2'b10) begin
        m_ti = int'(trk_int_word) + (1 << (T-1));
        m_frac = int'(trk_frac_word);
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    check_all("R1 reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sum;
    void'($urandom(seed));
    rst_n = 1'b1; mode = 2'b11; ref_tick = 1'b0;
    pvt_word = '0; acq_word = '0; trk_int_word = '0; trk_frac_word = '0;
    do_reset();

    // R2 extremes: most negative and most positive words per coarse bank
    mode = 2'b00; ref_tick = 1'b1; pvt_word = -32; step("R2 pvt min");
    pvt_word = 31; step("R2 pvt max");
    mode = 2'b01; acq_word = -4; step("R2 acq min");
    acq_word = 3; step("R2 acq max");
    // R3/R4: new words without strobe or in another mode are ignored
    ref_tick = 1'b0; acq_word = -2; pvt_word = 5; step("R4 no tick");
    mode = 2'b10; ref_tick = 1'b1; trk_int_word = 3; trk_frac_word = 8'd200;
    pvt_word = -7; acq_word = 1; step("R5 trk load");
    // R9 saturation at top: code 7 plus positive dither stays 7
    ref_tick = 1'b0;
    for (int i = 0; i < 20; i++) step("R9 sat hi");
    ref_tick = 1'b1; trk_int_word = -4; trk_frac_word = 8'd250;
    step("R5 trk load low");
    ref_tick = 1'b0;
    for (int i = 0; i < 20; i++) step("R9 sat lo");
    // R6 hold: nothing loads, dither drops to zero
    mode = 2'b11; ref_tick = 1'b1; trk_int_word = 1; pvt_word = 9; acq_word = 0;
    for (int i = 0; i < 4; i++) step("R6 hold");
    chk("R6 hold int code", 64'(trk_therm), unit(0));

    // R10 long-run mean of the dither
    do_reset();
    mode = 2'b10; ref_tick = 1'b1; trk_int_word = 0; trk_frac_word = 8'd77;
    step("R10 load");
    ref_tick = 1'b0; sum = 0;
    for (int i = 0; i < 256; i++) begin
      step("R10 run");
      sum += $countones(trk_therm) - 4;
    end
    n_chk++;
    if (sum != 77 && sum != 78) begin
      n_bad++;
      $display("FAIL R10 dither sum actual=%0d expected=77 or 78", sum);
    end

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      mode = (r < 2) ? 2'b00 : (r < 4) ? 2'b01 : (r < 8) ? 2'b10 : 2'b11;
      ref_tick = ($urandom_range(0, 3) == 0);
      pvt_word = P'($urandom); acq_word = A'($urandom);
      trk_int_word = T'($urandom); trk_frac_word = F'($urandom);
      step("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule